// File: doc/BRIEF.md
# Secure Real-Time Clock Register Block

This block keeps time as a 32-bit seconds count plus a 15-bit sub-second count. The sub-second count advances once for each cycle in which the `tick` input is high, and carries into the seconds count when it wraps. Software reaches seven 32-bit registers over a simple single-cycle bus. The registers are the two counter words, a 64-bit alarm split into high and low words, a control word holding the count enable, a status word, and an interrupt mask. Reads are combinational and have no side effects.

Writes to the counter, alarm and control words are posted. The bus accepts the write at once, a busy flag stays set for a fixed number of cycles, and then the value takes effect and a completion flag is set. A write that cannot be honoured sets an error flag and changes nothing. Software therefore polls for either completion or error after every write.

After reset the block sits in an invalid state that refuses all writes except those to the status word. The counter also stays frozen until its seconds word has been written once. A single status write then validates the block, after which software loads the time and enables counting.

Top module: `rtc_regblk`

## Requirements
- R1: After reset, the seconds, fraction, alarm, control and mask words read 0. Status reads 0x202 (write-next bit 9 and non-valid bit 1 set). `irq` is 0.
- R2: Word addresses are: 0 seconds, 1 fraction, 2 alarm high, 3 alarm low, 4 control, 5 status, 6 interrupt mask. The fraction value sits in bits 31:17 of its word with bits 16:0 reading 0. Control keeps only bit 3. The mask keeps only bits 9, 8, 7 and 4.
- R3: While non-valid (status bit 1) is set, a write to any address other than 5 sets write-error (bit 7) and leaves its target unchanged.
- R4: Non-valid clears only on a status write with bits 1 and 0 both set. A status write with bit 1 alone leaves it set.
- R5: An accepted write to addresses 0 to 4 sets write-busy (bit 10), clears write-next (bit 9) and write-complete (bit 8), and leaves the target unchanged for exactly 4 cycles. On the next cycle the new value is visible, busy clears and write-complete sets.
- R6: A write to addresses 0 to 4 while busy is rejected: write-error sets, and the pending write still completes with its own value.
- R7: Any write access to addresses 0 to 6 clears write-complete. Writes to status and mask take effect at once and set write-complete on the next cycle. Writing 1 clears error (bit 7), alarm (bit 4) or security-violation (bit 0).
- R8: The counter holds its value, even with control bit 3 set, until the seconds word has been written once after reset.
- R9: With control bit 3 set and seconds written once, each tick adds one to the fraction. A wrap of the fraction adds one to the seconds. A committed counter write takes precedence over a tick in the same cycle.
- R10: The alarm flag (bit 4) sets when a tick advances the counter to a value equal to {alarm high, alarm low}. It never sets while alarm high is 0xFFFFFFFF. Once set, it stays set until cleared.
- R11: `irq` is high when any of status bits 9, 8, 7 or 4 is set together with the same bit of the mask.
- R12: A write to address 7 has no effect on any register or flag. A read of address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick | input | 1 | Sub-second count enable pulse |
| irq | output | 1 | Masked OR of the interrupting status flags |

## Verification
On every cycle the embedded properties check the following:
- a write in the invalid state is flagged as an error;
- non-valid never clears without the paired status write;
- every valid write leaves busy, complete or error behind it;
- a posted write captures its data and busy drops after the commit;
- the counter stays still while not running;
- a fraction wrap carries one into the seconds;
- no alarm is raised while alarm high is all ones.

The exact four-cycle busy window, the value of the counter after a given number of ticks across the wrap point, the alarm firing on the precise tick, commit-over-tick precedence and the interrupt mask can only be shown by the bench's scenarios. The bench sweeps the starting fraction and tick counts around the wrap and computes the expected seconds and fraction arithmetically.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 7;

    localparam logic [ADDR_W-1:0] A_SEC    = 3'd0;
    localparam logic [ADDR_W-1:0] A_FRAC   = 3'd1;
    localparam logic [ADDR_W-1:0] A_ALM_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_ALM_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
    localparam logic [ADDR_W-1:0] A_IEN    = 3'd6;

    // status / mask bit positions (software-visible layout)
    localparam int B_BUSY = 10;
    localparam int B_NEXT = 9;
    localparam int B_DONE = 8;
    localparam int B_ERR  = 7;
    localparam int B_ALM  = 4;
    localparam int B_NV   = 1;
    localparam int B_SV   = 0;
    // control bit
    localparam int B_RUN  = 3;
endpackage

// File: rtl/rtc_post_engine.sv
module rtc_post_engine #(
    parameter int WR_LAT = 4,
    parameter int AW     = 3,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          busy_o,
    output logic          commit_o,
    output logic [AW-1:0] commit_addr_o,
    output logic [DW-1:0] commit_data_o
);
    localparam int CNT_W = (WR_LAT > 2) ? $clog2(WR_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_LAT - 1);

    typedef struct packed {
        logic          busy;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_LOAD;
            st_d.addr = addr_i;
            st_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o        = st_q.busy;
    assign commit_o      = st_q.busy && (st_q.cnt == '0);
    assign commit_addr_o = st_q.addr;
    assign commit_data_o = st_q.data;

    // an accepted posted write is held with the data it was issued with
    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && commit_data_o == $past(data_i)));
    // busy ends right after the commit cycle
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !busy_o);
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int DW     = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              ld_sec_i,
    input  logic              ld_frac_i,
    input  logic [DW-1:0]     ld_sec_val_i,
    input  logic [FRAC_W-1:0] ld_frac_val_i,
    input  logic [2*DW-1:0]   alarm_i,
    output logic [DW-1:0]     sec_o,
    output logic [DW-1:0]     frac_word_o,
    output logic              alarm_hit_o
);
    localparam int PAD_W = DW - FRAC_W;

    typedef struct packed {
        logic              seeded;
        logic [DW-1:0]     sec;
        logic [FRAC_W-1:0] frac;
    } tb_t;

    tb_t st_d, st_q;
    logic              adv;
    logic              carry;
    logic [FRAC_W-1:0] frac_inc;
    logic [DW-1:0]     sec_inc;

    always_comb begin
        st_d        = st_q;
        alarm_hit_o = 1'b0;
        adv         = run_i && st_q.seeded && tick_i && !ld_sec_i && !ld_frac_i;
        {carry, frac_inc} = {1'b0, st_q.frac} + (FRAC_W + 1)'(1);
        sec_inc     = st_q.sec + DW'(carry);
        if (adv) begin
            st_d.frac   = frac_inc;
            st_d.sec    = sec_inc;
            alarm_hit_o = ({sec_inc, frac_inc, {PAD_W{1'b0}}} == alarm_i)
                          && (alarm_i[2*DW-1:DW] != '1);
        end
        if (ld_frac_i) st_d.frac = ld_frac_val_i;
        if (ld_sec_i) begin
            st_d.sec    = ld_sec_val_i;
            st_d.seeded = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_o       = st_q.sec;
    assign frac_word_o = {st_q.frac, {PAD_W{1'b0}}};

    // frozen while not running or never seeded
    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_i && st_q.seeded) && !ld_sec_i && !ld_frac_i)
        |=> ($stable(st_q.sec) && $stable(st_q.frac)));
    // a wrap of the fraction carries one into the seconds
    assert_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && st_q.seeded && tick_i && !ld_sec_i && !ld_frac_i && (&st_q.frac))
        |=> (st_q.frac == '0 && st_q.sec == $past(st_q.sec) + 1'b1));
endmodule

// File: rtl/rtc_regblk.sv
module rtc_regblk
    import rtc_pkg::*;
#(
    parameter int WR_LAT = 4,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tick,
    output logic              irq
);
    typedef struct packed {
        logic [REG_W-1:0] alm_hi;
        logic [REG_W-1:0] alm_lo;
        logic             run;
        logic [3:0]       ien;   // {next, done, err, alm}
        logic             done;
        logic             err;
        logic             alm;
        logic             nv;
        logic             sv;
    } regs_t;

    regs_t st_d, st_q;

    logic              eng_busy, eng_commit;
    logic [ADDR_W-1:0] eng_addr;
    logic [REG_W-1:0]  eng_data;
    logic              alarm_hit;
    logic [REG_W-1:0]  sec_val, frac_word;
    logic              acc_ok, is_stat, is_ien, is_tk, reject, post_start, imm_ok;
    logic [REG_W-1:0]  stat_word;

    rtc_post_engine #(.WR_LAT(WR_LAT), .AW(ADDR_W), .DW(REG_W)) eng_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (post_start),
        .addr_i        (bus_addr),
        .data_i        (bus_wdata),
        .busy_o        (eng_busy),
        .commit_o      (eng_commit),
        .commit_addr_o (eng_addr),
        .commit_data_o (eng_data)
    );

    rtc_timebase #(.DW(REG_W), .FRAC_W(FRAC_W)) tb_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .run_i         (st_q.run),
        .ld_sec_i      (eng_commit && eng_addr == A_SEC),
        .ld_frac_i     (eng_commit && eng_addr == A_FRAC),
        .ld_sec_val_i  (eng_data),
        .ld_frac_val_i (eng_data[REG_W-1 -: FRAC_W]),
        .alarm_i       ({st_q.alm_hi, st_q.alm_lo}),
        .sec_o         (sec_val),
        .frac_word_o   (frac_word),
        .alarm_hit_o   (alarm_hit)
    );

    always_comb begin
        acc_ok     = bus_we && (bus_addr < ADDR_W'(NUM_REGS));
        is_stat    = (bus_addr == A_STAT);
        is_ien     = (bus_addr == A_IEN);
        is_tk      = !is_stat && !is_ien;
        reject     = acc_ok && ((st_q.nv && !is_stat) || (is_tk && eng_busy));
        post_start = acc_ok && is_tk && !reject;
        imm_ok     = acc_ok && !is_tk && !reject;

        st_d = st_q;
        if (acc_ok) st_d.done = 1'b0;
        if (reject) st_d.err  = 1'b1;
        if (imm_ok && is_stat) begin
            if (bus_wdata[B_ERR]) st_d.err = 1'b0;
            if (bus_wdata[B_ALM]) st_d.alm = 1'b0;
            if (bus_wdata[B_SV])  st_d.sv  = 1'b0;
            if (bus_wdata[B_NV] && bus_wdata[B_SV]) st_d.nv = 1'b0;
        end
        if (imm_ok && is_ien) begin
            st_d.ien = {bus_wdata[B_NEXT], bus_wdata[B_DONE],
                        bus_wdata[B_ERR], bus_wdata[B_ALM]};
        end
        if (imm_ok) st_d.done = 1'b1;
        if (eng_commit) begin
            st_d.done = 1'b1;
            case (eng_addr)
                A_ALM_HI: st_d.alm_hi = eng_data;
                A_ALM_LO: st_d.alm_lo = eng_data;
                A_CTRL:   st_d.run    = eng_data[B_RUN];
                default:  ;
            endcase
        end
        if (alarm_hit) st_d.alm = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.nv <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_word         = '0;
        stat_word[B_BUSY] = eng_busy;
        stat_word[B_NEXT] = !eng_busy;
        stat_word[B_DONE] = st_q.done;
        stat_word[B_ERR]  = st_q.err;
        stat_word[B_ALM]  = st_q.alm;
        stat_word[B_NV]   = st_q.nv;
        stat_word[B_SV]   = st_q.sv;

        bus_rdata = '0;
        case (bus_addr)
            A_SEC:    bus_rdata = sec_val;
            A_FRAC:   bus_rdata = frac_word;
            A_ALM_HI: bus_rdata = st_q.alm_hi;
            A_ALM_LO: bus_rdata = st_q.alm_lo;
            A_CTRL:   bus_rdata[B_RUN] = st_q.run;
            A_STAT:   bus_rdata = stat_word;
            A_IEN: begin
                bus_rdata[B_NEXT] = st_q.ien[3];
                bus_rdata[B_DONE] = st_q.ien[2];
                bus_rdata[B_ERR]  = st_q.ien[1];
                bus_rdata[B_ALM]  = st_q.ien[0];
            end
            default:  bus_rdata = '0;
        endcase

        irq = (st_q.ien[3] && !eng_busy) || (st_q.ien[2] && st_q.done)
           || (st_q.ien[1] && st_q.err)  || (st_q.ien[0] && st_q.alm);
    end

    // writes other than to status are refused while invalid
    assert_nv_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != A_STAT && bus_addr < ADDR_W'(NUM_REGS) && st_q.nv)
        |=> st_q.err);
    // invalid state leaves only through the paired status write
    assert_nv_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nv && !(bus_we && bus_addr == A_STAT && bus_wdata[B_NV] && bus_wdata[B_SV]))
        |=> st_q.nv);
    // every valid write leaves busy, complete or error behind it
    assert_write_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr < ADDR_W'(NUM_REGS)) |=> (st_q.done || st_q.err || eng_busy));
    // all-ones alarm high word never raises the alarm
    assert_alarm_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.alm_hi == '1 && !st_q.alm) |=> !st_q.alm);
endmodule

// File: tb/rtc_regblk_tb_top.sv
module rtc_regblk_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regblk dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick      (tick),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic wr_post(input logic [2:0] a, input logic [31:0] d);
        wr(a, d);
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] tot;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_reg("R1 sec", 3'd0, 32'h0);
        chk_reg("R1 frac", 3'd1, 32'h0);
        chk_reg("R1 alm_hi", 3'd2, 32'h0);
        chk_reg("R1 alm_lo", 3'd3, 32'h0);
        chk_reg("R1 ctrl", 3'd4, 32'h0);
        chk_reg("R1 status", 3'd5, 32'h202);
        chk_reg("R1 mask", 3'd6, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3 invalid state refuses writes
        wr(3'd4, 32'h8);
        chk_reg("R3 status err", 3'd5, 32'h282);
        chk_reg("R3 ctrl kept", 3'd4, 32'h0);
        wr(3'd6, 32'h390);
        chk_reg("R3 mask kept", 3'd6, 32'h0);
        wr(3'd0, 32'h5);
        repeat (5) @(negedge clk);
        chk_reg("R3 sec kept", 3'd0, 32'h0);
        chk_reg("R3 no busy", 3'd5, 32'h282);

        // R4 validation
        wr(3'd5, 32'h2);
        chk_reg("R4 nv alone", 3'd5, 32'h382);
        wr(3'd5, 32'h83);
        chk_reg("R4 nv cleared R7", 3'd5, 32'h300);

        // R5 posted write timing, R2 control masking
        wr(3'd4, 32'hFFFF_FFFF);
        chk_reg("R5 busy c0", 3'd5, 32'h400);
        chk_reg("R5 ctrl hidden", 3'd4, 32'h0);
        for (int c = 1; c < 4; c++) begin
            @(negedge clk);
            chk_reg("R5 busy hold", 3'd5, 32'h400);
            chk_reg("R5 ctrl hidden", 3'd4, 32'h0);
        end
        @(negedge clk);
        chk_reg("R5 complete", 3'd5, 32'h300);
        chk_reg("R2 ctrl bit3", 3'd4, 32'h8);

        // R8 frozen until seconds written
        ticks(10);
        chk_reg("R8 frac frozen", 3'd1, 32'h0);
        chk_reg("R8 sec frozen", 3'd0, 32'h0);

        // R9 counting after seed
        wr_post(3'd0, 32'd100);
        chk_reg("R9 sec load", 3'd0, 32'd100);
        ticks(5);
        chk_reg("R9 frac 5", 3'd1, 32'd5 << 17);

        // R6 write while busy
        wr(3'd0, 32'd7);
        wr(3'd1, 32'h0);
        chk_reg("R6 err busy", 3'd5, 32'h480);
        repeat (2) @(negedge clk);
        chk_reg("R6 done", 3'd5, 32'h380);
        chk_reg("R6 sec", 3'd0, 32'd7);
        chk_reg("R6 frac kept", 3'd1, 32'd5 << 17);
        wr(3'd5, 32'h80);
        chk_reg("R7 err w1c", 3'd5, 32'h300);

        // R9 sweep across the fraction wrap
        for (int k = 1; k <= 6; k++) begin
            for (int j = 0; j < 3; j++) begin
                n = (j == 0) ? k - 1 : ((j == 1) ? k : k + 3);
                wr_post(3'd1, (32'(32768 - k)) << 17);
                wr_post(3'd0, 32'(1000 + k));
                ticks(n);
                tot = 64'(1000 + k) * 64'd32768 + 64'(32768 - k) + 64'(n);
                chk_reg("R9 sweep sec", 3'd0, tot[46:15]);
                chk_reg("R9 sweep frac", 3'd1, {tot[14:0], 17'b0});
            end
        end

        // R10 alarm match
        wr_post(3'd0, 32'd50);
        wr_post(3'd1, 32'h0);
        wr_post(3'd2, 32'd50);
        wr_post(3'd3, 32'd4 << 17);
        chk_reg("R2 alm_lo read", 3'd3, 32'd4 << 17);
        ticks(3);
        chk_reg("R10 not yet", 3'd5, 32'h300);
        ticks(1);
        chk_reg("R10 alarm set", 3'd5, 32'h310);
        ticks(2);
        chk_reg("R10 alarm sticky", 3'd5, 32'h310);

        // R11 interrupt masking
        wr(3'd6, 32'h10);
        chk("R11 irq alarm", {31'b0, irq}, 32'h1);
        chk_reg("R2 mask read", 3'd6, 32'h10);
        wr(3'd5, 32'h10);
        chk_reg("R7 alarm w1c", 3'd5, 32'h300);
        chk("R11 irq off", {31'b0, irq}, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        chk_reg("R2 mask bits", 3'd6, 32'h390);
        chk("R11 irq next", {31'b0, irq}, 32'h1);
        wr(3'd6, 32'h80);
        chk("R11 irq no err", {31'b0, irq}, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd3, 32'h5);
        chk("R11 irq err", {31'b0, irq}, 32'h1);
        repeat (2) @(negedge clk);
        chk_reg("R6 alm_lo first", 3'd3, 32'h0);
        wr(3'd5, 32'h80);
        chk("R11 irq cleared", {31'b0, irq}, 32'h0);

        // R10 disabled alarm
        wr_post(3'd0, 32'hFFFF_FFFF);
        wr_post(3'd1, 32'h0);
        wr_post(3'd2, 32'hFFFF_FFFF);
        wr_post(3'd3, 32'd2 << 17);
        ticks(3);
        chk_reg("R10 disabled", 3'd5, 32'h300);
        chk_reg("R9 frac 3", 3'd1, 32'd3 << 17);

        // R9 commit precedence over tick
        tick = 1'b1;
        wr(3'd1, 32'h0);
        repeat (4) @(negedge clk);
        tick = 1'b0;
        chk_reg("R9 commit wins", 3'd1, 32'h0);
        chk_reg("R9 sec same", 3'd0, 32'hFFFF_FFFF);

        // R12 address 7
        wr(3'd7, 32'hFFFF_FFFF);
        chk_reg("R12 status", 3'd5, 32'h300);
        chk_reg("R12 read7", 3'd7, 32'h0);
        chk_reg("R12 ctrl", 3'd4, 32'h8);
        chk_reg("R12 mask", 3'd6, 32'h80);

        finish_run();
    end
endmodule